// File: doc/BRIEF.md
# Periodic Comparator Event Timer

This block is a memory-mapped event timer. It has one free-running 64-bit up-counter and one comparator channel. Software controls it through a plain 32-bit register port with an address, a write strobe, write data and registered read data. A general enable bit starts and pauses the counter. The counter can be preloaded through two 32-bit words. When the counter reaches the value held in the comparator, the block raises an interrupt. The channel runs either once (one-shot) or repeatedly (periodic). In periodic mode the period is added to the comparator on every match.

In periodic mode the comparator address acts as a two-step port. Software first sets the channel's self-clearing "load match" bit and writes the time of the first expiry. The hardware then clears the bit, so the next write to the same address lands in the period register. The interrupt is either a one-cycle pulse per match or a level that stays high until software clears it. A 32-bit mode restricts the compare to the low counter word.

Top module: `evt_timer`

## Requirements
- R1: Bit 0 of the general control word (byte offset 0x00) enables counting. While it is 0 the counter keeps its value, and setting it again resumes counting by one per clock from that value.
- R2: The counter is read and written as a low word at offset 0x08 and a high word at offset 0x0C. A write replaces that half, and the counter does not advance in the cycle of the write.
- R3: The channel control word at offset 0x10 holds these bits: level interrupt (bit 1), channel enable (bit 2), periodic (bit 3), load match (bit 6) and 32-bit mode (bit 8). All other bits are ignored and read as 0.
- R4: The comparator is at offsets 0x14 (low) and 0x18 (high). In one-shot mode a write loads the match value. A match (counter running, channel enabled, count equal to the comparator) gives a one-cycle edge pulse in the following cycle and leaves the comparator unchanged.
- R5: With periodic and load match both set, a comparator write loads the match value and clears the load-match bit in the same cycle.
- R6: With periodic set and load match clear, a comparator write loads only the period half and leaves the match value unchanged.
- R7: In periodic mode each match adds the period to the comparator, so matches recur every period cycles.
- R8: With the level bit set, a match sets status bit 0 at offset 0x04 and holds the interrupt high until software writes 1 to that bit. Writing 0 has no effect.
- R9: In 32-bit mode only the low 32 bits of the counter and comparator are compared, and the comparator high word reads as 0.
- R10: Reset clears every register. Read data shows the addressed register one cycle after the address is presented. Unused or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, pulse or level |

## Verification
A corrupted comparator or period register shows up at the interrupt pin on the next expected match. The pulse arrives early, late or not at all, and the comparator readback differs from the model one cycle after it is addressed. A load-match bit that fails to clear sends the second comparator write to the wrong register, which the read of the match value exposes at once. Because the bench model is compared on every clock, any divergence of the counter is reported on the first read that touches it, and an interrupt mistake is reported in the cycle it happens.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // word indexes of the register file (byte offset = index * 4)
  localparam int OFS_GCFG   = 0;
  localparam int OFS_ISTS   = 1;
  localparam int OFS_CNT_LO = 2;
  localparam int OFS_CNT_HI = 3;
  localparam int OFS_TCFG   = 4;
  localparam int OFS_CMP_LO = 5;
  localparam int OFS_CMP_HI = 6;
  localparam int NUM_REGS   = 7;

  // channel control bit positions
  localparam int TB_LEVEL = 1;
  localparam int TB_EN    = 2;
  localparam int TB_PER   = 3;
  localparam int TB_SETV  = 6;
  localparam int TB_W32   = 8;

  typedef struct packed {
    logic w32;
    logic setv;
    logic per;
    logic en;
    logic lvl;
  } tcfg_t;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign cnt_ce = run | wr_lo | wr_hi;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[DATA_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:DATA_W] = wdata;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_lo && !wr_hi |=> $stable(cnt_q)); // R1
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wr_lo && !wr_hi |=> cnt_q == $past(cnt_q) + 1'b1); // R1
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_run,
  input  logic              wr_tcfg,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic              wr_ists,
  input  logic [DATA_W-1:0] wdata,
  output tcfg_t             tcfg,
  output logic [CNT_W-1:0]  cmp,
  output logic              pend,
  output logic              irq
);
  tcfg_t            tcfg_q, tcfg_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d, reload;
  logic             pulse_q, pulse_d, pend_q, pend_d;
  logic             match, cmp_wr, to_match, to_period;

  assign match = cnt_run & tcfg_q.en &
                 (tcfg_q.w32 ? (cnt[DATA_W-1:0] == cmp_q[DATA_W-1:0]) : (cnt == cmp_q));
  assign cmp_wr    = wr_cmp_lo | wr_cmp_hi;
  assign to_match  = cmp_wr & (~tcfg_q.per | tcfg_q.setv);
  assign to_period = cmp_wr & tcfg_q.per & ~tcfg_q.setv;

  always_comb begin
    if (tcfg_q.w32)
      reload = {cmp_q[CNT_W-1:DATA_W], cmp_q[DATA_W-1:0] + per_q[DATA_W-1:0]};
    else
      reload = cmp_q + per_q;
  end

  always_comb begin
    tcfg_d  = tcfg_q;
    cmp_d   = cmp_q;
    per_d   = per_q;
    pulse_d = match & ~tcfg_q.lvl;
    pend_d  = pend_q;
    if (wr_tcfg) begin
      tcfg_d.lvl  = wdata[TB_LEVEL];
      tcfg_d.en   = wdata[TB_EN];
      tcfg_d.per  = wdata[TB_PER];
      tcfg_d.setv = wdata[TB_SETV];
      tcfg_d.w32  = wdata[TB_W32];
    end
    if (to_match) begin
      if (wr_cmp_lo) cmp_d[DATA_W-1:0]     = wdata;
      if (wr_cmp_hi) cmp_d[CNT_W-1:DATA_W] = wdata;
      if (tcfg_q.per) tcfg_d.setv = 1'b0;
    end else if (match && tcfg_q.per) begin
      cmp_d = reload;
    end
    if (to_period) begin
      if (wr_cmp_lo) per_d[DATA_W-1:0]     = wdata;
      if (wr_cmp_hi) per_d[CNT_W-1:DATA_W] = wdata;
    end
    if (match && tcfg_q.lvl)        pend_d = 1'b1;
    else if (wr_ists && wdata[0])   pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcfg_q  <= '0;
      cmp_q   <= '0;
      per_q   <= '0;
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      tcfg_q  <= tcfg_d;
      cmp_q   <= cmp_d;
      per_q   <= per_d;
      pulse_q <= pulse_d;
      pend_q  <= pend_d;
    end
  end

  assign tcfg = tcfg_q;
  assign cmp  = cmp_q;
  assign pend = pend_q;
  assign irq  = tcfg_q.lvl ? pend_q : pulse_q;

  AST_SETV_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr && tcfg_q.per && tcfg_q.setv |=> !tcfg_q.setv); // R5
  AST_PERIOD_WRITE_KEEPS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    to_period && !match |=> $stable(cmp_q)); // R6
  AST_PERIODIC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    match && tcfg_q.per && !tcfg_q.w32 && !cmp_wr |=> cmp_q == $past(cmp_q) + $past(per_q)); // R7
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tcfg_q.lvl && pend_q && !(wr_ists && wdata[0]) && !wr_tcfg |=> irq); // R8
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int IDX_W = ADDR_W - 2;

  logic                rst_meta_q, rst_sync_q;
  logic [IDX_W-1:0]    word_idx;
  logic                aligned;
  logic [NUM_REGS-1:0] wr_hit;
  logic                gcfg_q, gcfg_d;
  logic [CNT_W-1:0]    cnt, cmp;
  tcfg_t               tcfg;
  logic                pend;
  logic [DATA_W-1:0]   rd_d, rd_q;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_wr_dec
    assign wr_hit[gi] = bus_we & aligned & (word_idx == IDX_W'(gi));
  end

  assign gcfg_d = wr_hit[OFS_GCFG] ? bus_wdata[0] : gcfg_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) gcfg_q <= 1'b0;
    else             gcfg_q <= gcfg_d;
  end

  evt_main_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .run   (gcfg_q),
    .wr_lo (wr_hit[OFS_CNT_LO]),
    .wr_hi (wr_hit[OFS_CNT_HI]),
    .wdata (bus_wdata),
    .cnt   (cnt)
  );

  evt_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_channel (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cnt       (cnt),
    .cnt_run   (gcfg_q),
    .wr_tcfg   (wr_hit[OFS_TCFG]),
    .wr_cmp_lo (wr_hit[OFS_CMP_LO]),
    .wr_cmp_hi (wr_hit[OFS_CMP_HI]),
    .wr_ists   (wr_hit[OFS_ISTS]),
    .wdata     (bus_wdata),
    .tcfg      (tcfg),
    .cmp       (cmp),
    .pend      (pend),
    .irq       (irq)
  );

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      case (word_idx)
        IDX_W'(OFS_GCFG):   rd_d[0] = gcfg_q;
        IDX_W'(OFS_ISTS):   rd_d[0] = pend;
        IDX_W'(OFS_CNT_LO): rd_d = cnt[DATA_W-1:0];
        IDX_W'(OFS_CNT_HI): rd_d = cnt[CNT_W-1:DATA_W];
        IDX_W'(OFS_TCFG): begin
          rd_d[TB_LEVEL] = tcfg.lvl;
          rd_d[TB_EN]    = tcfg.en;
          rd_d[TB_PER]   = tcfg.per;
          rd_d[TB_SETV]  = tcfg.setv;
          rd_d[TB_W32]   = tcfg.w32;
        end
        IDX_W'(OFS_CMP_LO): rd_d = cmp[DATA_W-1:0];
        IDX_W'(OFS_CMP_HI): rd_d = tcfg.w32 ? '0 : cmp[CNT_W-1:DATA_W];
        default:            rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

  AST_GCFG_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wr_hit[OFS_GCFG] |=> gcfg_q == $past(bus_wdata[0])); // R1
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int    checks = 0;
  int    failures = 0;
  int    pulses = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  // behavioural reference state
  logic [63:0] m_cnt, m_cmp, m_perv;
  logic [31:0] m_rdata;
  bit m_gen, m_lvl, m_en, m_per, m_setv, m_w32, m_pend, m_pulse;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_gen};
      8'h04: return {31'b0, m_pend};
      8'h08: return m_cnt[31:0];
      8'h0C: return m_cnt[63:32];
      8'h10: return 32'(m_lvl) << 1 | 32'(m_en) << 2 | 32'(m_per) << 3 |
                    32'(m_setv) << 6 | 32'(m_w32) << 8;
      8'h14: return m_cmp[31:0];
      8'h18: return m_w32 ? 32'h0 : m_cmp[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_perv = 0; m_rdata = 0;
      m_gen = 0; m_lvl = 0; m_en = 0; m_per = 0; m_setv = 0; m_w32 = 0;
      m_pend = 0; m_pulse = 0;
    end else begin
      bit hit, cw;
      logic [63:0] n_cnt, n_cmp, n_perv;
      bit n_setv, n_pend;
      hit = m_gen && m_en && (m_w32 ? (m_cnt[31:0] == m_cmp[31:0]) : (m_cnt == m_cmp));
      m_rdata = model_read(addr);
      n_cnt = m_cnt; n_cmp = m_cmp; n_perv = m_perv; n_setv = m_setv; n_pend = m_pend;
      if (we && addr == 8'h08)      n_cnt = {m_cnt[63:32], wdata};
      else if (we && addr == 8'h0C) n_cnt = {wdata, m_cnt[31:0]};
      else if (m_gen)               n_cnt = m_cnt + 64'd1;
      cw = we && (addr == 8'h14 || addr == 8'h18);
      if (cw && (!m_per || m_setv)) begin
        if (addr == 8'h14) n_cmp[31:0] = wdata; else n_cmp[63:32] = wdata;
        if (m_per) n_setv = 0;
      end else if (hit && m_per) begin
        if (m_w32) n_cmp[31:0] = m_cmp[31:0] + m_perv[31:0];
        else       n_cmp = m_cmp + m_perv;
      end
      if (cw && m_per && !m_setv) begin
        if (addr == 8'h14) n_perv[31:0] = wdata; else n_perv[63:32] = wdata;
      end
      if (hit && m_lvl) n_pend = 1;
      else if (we && addr == 8'h04 && wdata[0]) n_pend = 0;
      m_pulse = hit && !m_lvl;
      if (we && addr == 8'h00) m_gen = wdata[0];
      if (we && addr == 8'h10) begin
        m_lvl = wdata[1]; m_en = wdata[2]; m_per = wdata[3];
        n_setv = wdata[6]; m_w32 = wdata[8];
      end
      m_cnt = n_cnt; m_cmp = n_cmp; m_perv = n_perv; m_setv = n_setv; m_pend = n_pend;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_irq;
      exp_irq = m_lvl ? m_pend : m_pulse;
      checks++;
      if (rdata !== m_rdata) begin
        failures++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
      end
      checks++;
      if (irq !== exp_irq) begin
        failures++;
        $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, exp_irq);
      end
      if (irq) pulses++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R10: everything zero after reset, plus a misaligned address
    cur_req = "R10";
    for (int a = 0; a < 7; a++) begin
      rd(8'(a * 4), v); chk("R10 reset value", v, 32'h0);
    end
    rd(8'h09, v); chk("R10 misaligned", v, 32'h0);

    // R2: preload counter while stopped
    cur_req = "R2";
    wr(8'h08, 32'h100); wr(8'h0C, 32'h2);
    rd(8'h08, v); chk("R2 counter low", v, 32'h100);
    rd(8'h0C, v); chk("R2 counter high", v, 32'h2);

    // R1: run, stop, hold, resume
    cur_req = "R1";
    wr(8'h00, 32'h1); idle(10); wr(8'h00, 32'h0);
    rd(8'h08, v); rd(8'h08, v2);
    chk("R1 held while stopped", v2, v);
    chk("R1 advanced while running", 32'(v > 32'h100), 32'h1);
    wr(8'h00, 32'h1); idle(3); wr(8'h00, 32'h0);
    rd(8'h08, v2); chk("R1 resumed from held value", 32'(v2 > v), 32'h1);

    // R3: only defined control bits stick
    cur_req = "R3";
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R3 control bits", v, 32'h0000_014E);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R3 control cleared", v, 32'h0);

    // R4: one-shot edge interrupt
    cur_req = "R4";
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h10, 32'h4); wr(8'h18, 0); wr(8'h14, 30);
    p0 = pulses;
    wr(8'h00, 1); idle(60); wr(8'h00, 0);
    chk("R4 single pulse", 32'(pulses - p0), 32'd1);
    rd(8'h14, v); chk("R4 comparator unchanged", v, 32'd30);

    // R5/R6: two-step comparator port in periodic mode
    cur_req = "R5";
    wr(8'h08, 0); wr(8'h10, 32'h4C); wr(8'h14, 20);
    rd(8'h10, v); chk("R5 load-match bit self-cleared", v, 32'h0C);
    cur_req = "R6";
    wr(8'h14, 15);
    rd(8'h14, v); chk("R6 match value kept after period write", v, 32'd20);

    // R7: periodic reload
    cur_req = "R7";
    p0 = pulses;
    wr(8'h00, 1); idle(80); wr(8'h00, 0);
    chk("R7 recurring pulses", 32'(pulses - p0 >= 4), 32'h1);
    rd(8'h14, v);
    chk("R7 comparator stepped by period", 32'(v > 20 && (v - 20) % 15 == 0), 32'h1);

    // R8: level interrupt and status clear
    cur_req = "R8";
    wr(8'h10, 0); wr(8'h08, 0); wr(8'h14, 10); wr(8'h10, 32'h6);
    wr(8'h00, 1); idle(30); wr(8'h00, 0);
    chk("R8 level held", 32'(irq), 32'h1);
    rd(8'h04, v); chk("R8 status bit", v, 32'h1);
    wr(8'h04, 0);
    chk("R8 write 0 ignored", 32'(irq), 32'h1);
    wr(8'h04, 1);
    chk("R8 write 1 clears", 32'(irq), 32'h0);

    // R9: 32-bit compare
    cur_req = "R9";
    wr(8'h10, 0); wr(8'h0C, 5); wr(8'h08, 0);
    wr(8'h10, 32'h104); wr(8'h18, 7); wr(8'h14, 12);
    rd(8'h18, v); chk("R9 high comparator reads zero", v, 32'h0);
    p0 = pulses;
    wr(8'h00, 1); idle(30); wr(8'h00, 0);
    chk("R9 low-word match", 32'(pulses - p0), 32'd1);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule